// File: doc/BRIEF.md
# Input-Queued Crossbar With Blocking Feedback

This block is an N-by-N cell switch. Each input has a small FIFO, and the fabric between inputs and outputs holds no cells. In every clock cycle (one slot), each input with a non-empty FIFO presents its oldest cell to the crosspoint column of that cell's destination. Each column settles contention by itself. A crosspoint switches to the connecting state only when the cell it sees is addressed to its output and no crosspoint above it in the same column has already claimed that output in this slot. Every crosspoint returns to the idle state at the next slot, so no connection carries over from one slot to the next.

A cell that fails to get its output is not lost. The block raises a per-input blocking flag, keeps the cell at the head of its FIFO, and offers it again in the next slot. Winning cells leave their FIFO and appear one cycle later on a valid-plus-data stream at their output. Each FIFO raises a full flag so that the upstream source holds its cell until there is room.

Top module: `xbar_iq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, all FIFOs are empty, and out_valid, in_full and in_block are all zero.
- R2: A head cell whose destination field (in_dest bits [i*DW +: DW], DW = log2 N) names output j, and which is not blocked, appears on out_valid[j] and out_data[j*W +: W] in the following cycle. A cell accepted in cycle t can leave in cycle t+1 at the earliest.
- R3: When several head cells address the same output in one slot, only the lowest-numbered input passes. Every other contender has in_block high in that slot.
- R4: A blocked cell is not forwarded. It stays at the head of its FIFO and requests the same output again in the next slot.
- R5: The cells of any one input leave in the order in which they were accepted.
- R6: in_full[i] is high exactly when FIFO i holds DEPTH cells. While in_full[i] is high, in_valid[i] is ignored, even in a cycle in which the head cell leaves.
- R7: Each output carries at most one cell per slot. out_valid[j] is low in every cycle that follows a slot in which no head cell addressed output j.
- R8: in_block[i] is low whenever FIFO i is empty, and whenever its head cell is the only cell, or the lowest-numbered cell, addressing its output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N | Per-input cell offer |
| in_dest | input | N*DW | Per-input destination output index |
| in_data | input | N*W | Per-input cell payload |
| in_full | output | N | Per-input FIFO full; the source must hold its cell |
| in_block | output | N | Per-input flag: the head cell lost its crosspoint this slot |
| out_valid | output | N | Per-output cell present |
| out_data | output | N*W | Per-output cell payload |

## Verification
The bench builds the block with N = 4, W = 8 and DEPTH = 4. With the shallow FIFO, a few slots of traffic all addressed to output 0 fill the FIFOs of the higher-numbered inputs. This exercises the full flag, offers that are ignored while a FIFO is full, and long strings of retries by the same blocked cell. Four inputs give three-way and four-way contention for one column, as well as permutation traffic in which no cell is blocked. A behavioural queue model predicts the blocking flags, full flags and output streams for every cycle of the directed and random traffic.

// File: rtl/xbar_iq.sv
`timescale 1ns/1ps
module xbar_iq #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N-1:0]                     in_valid,
  input  logic [N*((N>1)?$clog2(N):1)-1:0] in_dest,
  input  logic [N*W-1:0]                   in_data,
  output logic [N-1:0]                     in_full,
  output logic [N-1:0]                     in_block,
  output logic [N-1:0]                     out_valid,
  output logic [N*W-1:0]                   out_data
);
  localparam int DW = (N > 1) ? $clog2(N) : 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + W;

  logic [EW-1:0] mem [N][DEPTH];
  logic [AW-1:0] rp [N];
  logic [AW-1:0] wp [N];
  logic [CW-1:0] cnt [N];

  wire [N-1:0]    hv;
  wire [N-1:0]    push;
  wire [N-1:0]    pop;
  wire [N*DW-1:0] hdst_f;
  wire [N*W-1:0]  hdat_f;
  wire [N*CW-1:0] cnt_f;
  wire [N-1:0]    bar  [N];
  wire [N:0]      busy [N];
  logic [N*W-1:0] col_data;

  genvar i, j;
  generate
    for (i = 0; i < N; i++) begin : g_in
      assign hv[i]   = cnt[i] != '0;
      assign {hdst_f[i*DW +: DW], hdat_f[i*W +: W]} = mem[i][rp[i]];
      assign cnt_f[i*CW +: CW] = cnt[i];
      assign in_full[i]  = cnt[i] == CW'(DEPTH);
      assign push[i]     = in_valid[i] & ~in_full[i];
      assign pop[i]      = |bar[i];
      assign in_block[i] = hv[i] & ~pop[i];
    end
    for (j = 0; j < N; j++) begin : g_col
      assign busy[j][0] = 1'b0;
      for (i = 0; i < N; i++) begin : g_xp
        wire req = hv[i] && (hdst_f[i*DW +: DW] == DW'(j));
        assign bar[i][j]    = req & ~busy[j][i];
        assign busy[j][i+1] = busy[j][i] | req;
      end
    end
  endgenerate

  always_comb begin
    col_data = '0;
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++)
        if (bar[r][c]) col_data[c*W +: W] = col_data[c*W +: W] | hdat_f[r*W +: W];
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < N; r++)
      if (push[r]) mem[r][wp[r]] <= {in_dest[r*DW +: DW], in_data[r*W +: W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin
        rp[r]  <= '0;
        wp[r]  <= '0;
        cnt[r] <= '0;
      end
      out_valid <= '0;
      out_data  <= '0;
    end else begin
      for (int r = 0; r < N; r++) begin
        if (push[r]) wp[r] <= (wp[r] == AW'(DEPTH - 1)) ? '0 : wp[r] + 1'b1;
        if (pop[r])  rp[r] <= (rp[r] == AW'(DEPTH - 1)) ? '0 : rp[r] + 1'b1;
        cnt[r] <= cnt[r] + CW'(push[r]) - CW'(pop[r]);
      end
      for (int c = 0; c < N; c++) out_valid[c] <= busy[c][N];
      out_data <= col_data;
    end
  end
endmodule

// File: rtl/xbar_iq_chk.sv
`timescale 1ns/1ps
module xbar_iq_chk #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int DW    = (N > 1) ? $clog2(N) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   in_valid,
  input logic [N-1:0]   in_full,
  input logic [N-1:0]   in_block,
  input logic [N-1:0]   out_valid,
  input logic [N-1:0]   hv,
  input logic [N*DW-1:0] hdst_f,
  input logic [N*W-1:0] hdat_f,
  input logic [N*CW-1:0] cnt_f
);
  logic [N-1:0] want, beat;

  always_comb begin
    want = '0;
    beat = '0;
    for (int a = 0; a < N; a++) begin
      if (hv[a] && !in_block[a]) want[hdst_f[a*DW +: DW]] = 1'b1;
      for (int b = 0; b < a; b++)
        if (hv[b] && !in_block[b] && hdst_f[b*DW +: DW] == hdst_f[a*DW +: DW]) beat[a] = 1'b1;
    end
  end

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_a
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full[k] && in_valid[k]) |=> cnt_f[k*CW +: CW] <= $past(cnt_f[k*CW +: CW])); // R6
      AST_BLOCK_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        in_block[k] |-> hv[k]); // R8
      AST_LOSER_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        in_block[k] |-> beat[k]); // R3
      AST_BLOCKED_CELL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_block[k] |=> hv[k] && hdst_f[k*DW +: DW] == $past(hdst_f[k*DW +: DW])
                        && hdat_f[k*W +: W] == $past(hdat_f[k*W +: W])); // R4
      AST_OUT_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        want[k] |=> out_valid[k]); // R2
      AST_OUT_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !want[k] |=> !out_valid[k]); // R7
    end
  endgenerate
endmodule

bind xbar_iq xbar_iq_chk #(.N(N), .W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_full(in_full),
  .in_block(in_block), .out_valid(out_valid), .hv(hv), .hdst_f(hdst_f),
  .hdat_f(hdat_f), .cnt_f(cnt_f)
);

// File: tb/sim_xbar_iq.sv
`timescale 1ns/1ps
module sim_xbar_iq;
  localparam int N = 4, W = 8, DEPTH = 4, DW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    in_valid = '0;
  logic [N*DW-1:0] in_dest = '0;
  logic [N*W-1:0]  in_data = '0;
  logic [N-1:0]    in_full, in_block, out_valid;
  logic [N*W-1:0]  out_data;

  xbar_iq #(.N(N), .W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .in_full(in_full), .in_block(in_block),
    .out_valid(out_valid), .out_data(out_data)
  );

  int q [N][$];
  bit exp_ov [N];
  int exp_od [N];
  int n_chk = 0, n_fail = 0;
  bit dv [N];
  int dd [N];
  int dx [N];
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    int win [N];
    int sz [N];
    int d;
    @(negedge clk);
    for (int j = 0; j < N; j++) win[j] = -1;
    for (int i = 0; i < N; i++) begin
      sz[i] = q[i].size();
      if (sz[i] > 0) begin
        d = q[i][0] >> W;
        if (win[d] < 0) win[d] = i;
      end
    end
    for (int i = 0; i < N; i++) begin
      bit eb = (sz[i] > 0) && (win[q[i][0] >> W] != i);
      chk(in_block[i] == eb, "R3 R4 R8", $sformatf("in_block[%0d]", i), in_block[i], eb);
      chk(in_full[i] == (sz[i] == DEPTH), "R6", $sformatf("in_full[%0d]", i), in_full[i], sz[i] == DEPTH);
    end
    for (int j = 0; j < N; j++) begin
      chk(out_valid[j] == exp_ov[j], "R2 R7", $sformatf("out_valid[%0d]", j), out_valid[j], exp_ov[j]);
      if (exp_ov[j])
        chk(int'(out_data[j*W +: W]) == exp_od[j], "R2 R5", $sformatf("out_data[%0d]", j),
            out_data[j*W +: W], exp_od[j]);
    end
    for (int i = 0; i < N; i++) begin
      in_valid[i] = dv[i];
      in_dest[i*DW +: DW] = DW'(dd[i]);
      in_data[i*W +: W] = W'(dx[i]);
    end
    for (int j = 0; j < N; j++) begin
      exp_ov[j] = win[j] >= 0;
      if (win[j] >= 0) begin
        exp_od[j] = q[win[j]][0] & ((1 << W) - 1);
        void'(q[win[j]].pop_front());
      end
    end
    for (int i = 0; i < N; i++)
      if (dv[i] && sz[i] < DEPTH) q[i].push_back((dd[i] << W) | (dx[i] & ((1 << W) - 1)));
  endtask

  task automatic idle();
    for (int i = 0; i < N; i++) dv[i] = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    for (int j = 0; j < N; j++) begin exp_ov[j] = 0; exp_od[j] = 0; end
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_full == '0, "R1", "in_full in reset", in_full, 0);
    chk(in_block == '0, "R1", "in_block in reset", in_block, 0);
    rst_n = 1'b1;

    // permutation traffic: no contention
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < N; i++) begin dv[i] = 1; dd[i] = (i + s) % N; dx[i] = 16 * s + i; end
      tick();
    end
    idle();
    repeat (4) tick();

    // all inputs to output 0: contention, retries and full FIFOs
    for (int s = 0; s < 12; s++) begin
      for (int i = 0; i < N; i++) begin dv[i] = 1; dd[i] = 0; dx[i] = 100 + 8 * s + i; end
      tick();
    end
    idle();
    repeat (24) tick();

    // two inputs share a column, others run free
    for (int s = 0; s < 10; s++) begin
      dv[0] = 1; dd[0] = 3; dx[0] = s;
      dv[1] = 1; dd[1] = 1; dx[1] = 50 + s;
      dv[2] = 1; dd[2] = 3; dx[2] = 70 + s;
      dv[3] = (s % 2) == 0; dd[3] = 2; dx[3] = 90 + s;
      tick();
    end
    idle();
    repeat (24) tick();

    // random traffic
    for (int s = 0; s < 3000; s++) begin
      for (int i = 0; i < N; i++) begin
        dv[i] = ($urandom % 10) < 6;
        dd[i] = $urandom % N;
        dx[i] = $urandom % 256;
      end
      tick();
    end
    idle();
    repeat (40) tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule